// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block carries out one block load or block store that moves up to sixteen registers between a register file and word-addressed memory. A command gives a 16-bit register list, the index and current value of a base register, a direction flag, one of four addressing modes, a writeback flag and a condition-pass flag. Three more flags select the compact list encoding, the stack-pop form and the exception-return load. The sequencer works out the lowest address from the number of listed registers. It then issues one word access for each listed register, starting at the lowest register index, with the address rising by one word per access.

On a load, words go to the register file through its write port. A word for register 15 leaves as a branch target on a separate strobe. The exception-return load fetches one extra word after the general registers as the new program counter, and raises a strobe that tells the core to restore its status word from the saved copy. Writeback updates the base register once, after the last access. Commands the architecture leaves undefined are flagged in the cycle they are accepted, and such a command moves no data.

Top module: `mreg_xfer`

## Requirements
- R1: `cmdMode` bit 1 means incrementing and bit 0 means the "before" variant. With S = 4 × (set bits in the list), plus 4 for exception return, the first access address is: base for mode 2'b10, base+4 for 2'b11, base−S+4 for 2'b00, base−S for 2'b01.
- R2: Listed registers 0..14 are accessed in ascending index order. Each access is one word above the previous one, in every mode, and there is exactly one access per listed register.
- R3: A listed register 15 is transferred last. On a load, its word appears on `pcWrData` with `pcWrEn` and is never written through the register-file port. On a store, the value read from register-file index 15 is stored.
- R4: With writeback, the base register is written once in the `done` cycle. The value is base+S for incrementing modes and base−S for decrementing modes. `baseOut` shows the new base in the `done` cycle, or the unchanged base when there is no writeback.
- R5: On a store with writeback, a base register that is listed but is not the lowest listed register is stored as zero. When it is the lowest listed register, its true value is stored.
- R6: On a load with writeback where the base register is listed, the base register ends at zero instead of the updated address.
- R7: In the stack-pop form, a load with list bit 15 set whose final address has low two bits other than 00 is unpredictable.
- R8: An exception-return load (list bit 15 clear) reads one extra word after the listed registers. That word goes out on `pcWrEn`/`pcWrData` together with a one-cycle `statusRestore`, and S includes the extra 4 bytes. An exception-return store, or one with list bit 15 set, is unpredictable.
- R9: The following are unpredictable: base index 15; an empty list in the full encoding; fewer than two listed registers in the compact encoding; and list bits 15 and 14 both set in the compact encoding.
- R10: When `cmdCondPass` is low, the command makes no memory request, writes no register, raises no flag, and `done` pulses in the cycle after acceptance.
- R11: A command is accepted only while `cmdReady` is high. `memReq` and `memAddr` hold until `memReady` is seen. `done` is a single-cycle pulse.
- R12: `unpredictable` is high only in the acceptance cycle of an offending command that passes its condition. Such a command makes no access and no register write, and it finishes with `done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Sequencer idle, command accepted this cycle if valid |
| cmdList | input | 16 | Register list, bit i selects register i |
| cmdBaseIdx | input | 4 | Base register index |
| cmdBaseVal | input | 32 | Current base register value |
| cmdLoad | input | 1 | 1 = load, 0 = store |
| cmdMode | input | 2 | Addressing mode (bit 1 increment, bit 0 before) |
| cmdWback | input | 1 | Update base register at the end |
| cmdCondPass | input | 1 | Condition check result |
| cmdCompact | input | 1 | Compact list encoding rules apply |
| cmdPopForm | input | 1 | Stack-pop form with unaligned access allowed |
| cmdExcRet | input | 1 | Exception-return load |
| unpredictable | output | 1 | Command rejected as unpredictable |
| done | output | 1 | Command finished (one cycle) |
| memReq | output | 1 | Memory word request |
| memWrite | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Store data |
| memReady | input | 1 | Memory accepts / answers the request this cycle |
| memRdata | input | 32 | Load data, valid with memReady |
| rfRdIdx | output | 4 | Register-file read index |
| rfRdData | input | 32 | Register-file read data (combinational) |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrIdx | output | 4 | Register-file write index |
| rfWrData | output | 32 | Register-file write data |
| pcWrEn | output | 1 | Branch-target strobe |
| pcWrData | output | 32 | Branch target |
| statusRestore | output | 1 | Restore status word from saved copy |
| baseOut | output | 32 | Resulting base value, valid with done |

## Verification
The assertions assume a memory that returns `memRdata` combinationally in the same cycle as `memReady`, and a register file whose read data follows `rfRdIdx` in the same cycle. They also assume that `cmdValid` is offered only for one cycle at a time against an idle sequencer. The bench keeps to this. It models the register file and memory combinationally, holds each command for exactly one cycle while `cmdReady` is high, and varies `memReady` at random so that request holding is exercised. Random commands stay in the full encoding with a non-empty list and a base below 15. The unpredictable, compact, pop and exception-return cases are reached through directed commands.

// File: rtl/mreg_xfer_pkg.sv
package mreg_xfer_pkg;
  localparam int DATA_W = 32;
  localparam int REG_N  = 16;
  localparam int IDX_W  = $clog2(REG_N);
  localparam int WORD_B = DATA_W / 8;

  // bit 1: incrementing, bit 0: adjust before access
  typedef enum logic [1:0] {
    MODE_DA = 2'b00,
    MODE_DB = 2'b01,
    MODE_IA = 2'b10,
    MODE_IB = 2'b11
  } xferMode_t;

  typedef struct packed {
    logic load;    // latch a new command
    logic step;    // one memory word completed
    logic finish;  // closing cycle, writeback slot
  } seqStrobe_t;

  function automatic logic [IDX_W:0] countOnes(input logic [REG_N-1:0] v);
    logic [IDX_W:0] n;
    n = '0;
    for (int i = 0; i < REG_N; i++) n = n + {{IDX_W{1'b0}}, v[i]};
    return n;
  endfunction

  function automatic logic [IDX_W-1:0] lowestSet(input logic [REG_N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = REG_N - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/mreg_xfer_ctrl.sv
module mreg_xfer_ctrl
  import mreg_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       abortCmd,
  input  logic       lastBeat,
  input  logic       memReady,
  output logic       cmdReady,
  output logic       memReq,
  output logic       done,
  output seqStrobe_t st
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FIN} seqState_t;
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE: if (cmdValid) nextState = abortCmd ? S_FIN : S_XFER;
      S_XFER: if (memReady && lastBeat) nextState = S_FIN;
      S_FIN:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign cmdReady  = (state == S_IDLE);
  assign memReq    = (state == S_XFER);
  assign done      = (state == S_FIN);
  assign st.load   = cmdReady && cmdValid;
  assign st.step   = memReq && memReady;
  assign st.finish = done;

  // R11: a request stays up until the memory answers
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> memReq);
  // R11: completion is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10 / R12: a rejected or condition-failed command skips all transfers
  assert_abort_skip_R10: assert property (@(posedge clk) disable iff (!rstN)
    (st.load && abortCmd) |=> (!memReq && done));
endmodule

// File: rtl/mreg_xfer_dp.sv
module mreg_xfer_dp
  import mreg_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        st,
  input  logic [REG_N-1:0]  cmdList,
  input  logic [IDX_W-1:0]  cmdBaseIdx,
  input  logic [DATA_W-1:0] cmdBaseVal,
  input  logic              cmdLoad,
  input  xferMode_t         cmdMode,
  input  logic              cmdWback,
  input  logic              cmdCondPass,
  input  logic              cmdCompact,
  input  logic              cmdPopForm,
  input  logic              cmdExcRet,
  output logic              abortCmd,
  output logic              unpredictable,
  output logic              lastBeat,
  output logic [DATA_W-1:0] memAddr,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              pcWrEn,
  output logic [DATA_W-1:0] pcWrData,
  output logic              statusRestore,
  output logic [DATA_W-1:0] baseOut
);
  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(REG_N - 1);

  logic [IDX_W:0]    listCnt;
  logic [DATA_W-1:0] sizeB, lowAddr, startAddr, finalAddr, newBase;
  logic              isInc, isBefore, badForm;

  logic [REG_N-1:0]  pending;
  logic              extraPend, loadR, wbEnR;
  logic [DATA_W-1:0] addrR, baseOutR;
  logic [IDX_W-1:0]  baseIdxR, lowestR, curIdx;
  logic [IDX_W+1:0]  remaining;
  logic              pcBeat;

  // command decode and start address
  assign listCnt   = countOnes(cmdList);
  assign sizeB     = DATA_W'((32'(listCnt) + 32'(cmdExcRet)) * WORD_B);
  assign isInc     = cmdMode[1];
  assign isBefore  = cmdMode[0];
  assign lowAddr   = isInc ? cmdBaseVal : cmdBaseVal - sizeB;
  assign startAddr = lowAddr + ((isInc == isBefore) ? DATA_W'(WORD_B) : '0);
  assign finalAddr = startAddr + sizeB - DATA_W'(WORD_B);
  assign newBase   = (cmdLoad && cmdList[cmdBaseIdx]) ? '0
                   : (isInc ? cmdBaseVal + sizeB : cmdBaseVal - sizeB);

  assign badForm = (cmdBaseIdx == PC_IDX)
                || (cmdCompact ? ((listCnt < 2) || (&cmdList[REG_N-1:REG_N-2]))
                               : (listCnt == '0))
                || (cmdExcRet && (!cmdLoad || cmdList[REG_N-1]))
                || (cmdPopForm && cmdLoad && cmdList[REG_N-1] && (finalAddr[1:0] != 2'b00));

  assign abortCmd      = !cmdCondPass || badForm;
  assign unpredictable = st.load && cmdCondPass && badForm;

  // beat selection
  assign curIdx    = (pending == '0) ? PC_IDX : lowestSet(pending);
  assign pcBeat    = (curIdx == PC_IDX);
  assign remaining = {1'b0, countOnes(pending)} + {{(IDX_W+1){1'b0}}, extraPend};
  assign lastBeat  = (remaining == (IDX_W+2)'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= '0;
      extraPend <= 1'b0;
      addrR     <= '0;
      loadR     <= 1'b0;
      wbEnR     <= 1'b0;
      baseIdxR  <= '0;
      lowestR   <= '0;
      baseOutR  <= '0;
    end else if (st.load) begin
      pending   <= abortCmd ? '0
                 : (cmdExcRet ? {1'b0, cmdList[REG_N-2:0]} : cmdList);
      extraPend <= !abortCmd && cmdExcRet;
      addrR     <= startAddr;
      loadR     <= cmdLoad;
      wbEnR     <= cmdWback && !abortCmd;
      baseIdxR  <= cmdBaseIdx;
      lowestR   <= lowestSet(cmdList);
      baseOutR  <= (cmdWback && !abortCmd) ? newBase : cmdBaseVal;
    end else if (st.step) begin
      addrR <= addrR + DATA_W'(WORD_B);
      if (pending != '0) pending[curIdx] <= 1'b0;
      else               extraPend       <= 1'b0;
    end
  end

  assign memAddr  = addrR;
  assign memWrite = !loadR;
  assign rfRdIdx  = curIdx;
  assign memWdata = (!loadR && wbEnR && curIdx == baseIdxR && curIdx != lowestR)
                  ? '0 : rfRdData;

  assign pcWrEn        = st.step && loadR && pcBeat;
  assign pcWrData      = memRdata;
  assign statusRestore = st.step && loadR && (pending == '0);
  assign baseOut       = baseOutR;

  always_comb begin
    rfWrEn   = 1'b0;
    rfWrIdx  = curIdx;
    rfWrData = memRdata;
    if (st.finish && wbEnR) begin
      rfWrEn   = 1'b1;
      rfWrIdx  = baseIdxR;
      rfWrData = baseOutR;
    end else if (st.step && loadR && !pcBeat) begin
      rfWrEn = 1'b1;
    end
  end

  // R3: the branch-target word is always the final beat
  assert_pc_last_R3: assert property (@(posedge clk) disable iff (!rstN)
    pcWrEn |-> lastBeat);
  // R3: a register-15 beat never goes through the register-file port
  assert_pc_not_rf_R3: assert property (@(posedge clk) disable iff (!rstN)
    pcWrEn |-> !rfWrEn);
endmodule

// File: rtl/mreg_xfer.sv
module mreg_xfer
  import mreg_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  output logic        cmdReady,
  input  logic [15:0] cmdList,
  input  logic [3:0]  cmdBaseIdx,
  input  logic [31:0] cmdBaseVal,
  input  logic        cmdLoad,
  input  logic [1:0]  cmdMode,
  input  logic        cmdWback,
  input  logic        cmdCondPass,
  input  logic        cmdCompact,
  input  logic        cmdPopForm,
  input  logic        cmdExcRet,
  output logic        unpredictable,
  output logic        done,
  output logic        memReq,
  output logic        memWrite,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memReady,
  input  logic [31:0] memRdata,
  output logic [3:0]  rfRdIdx,
  input  logic [31:0] rfRdData,
  output logic        rfWrEn,
  output logic [3:0]  rfWrIdx,
  output logic [31:0] rfWrData,
  output logic        pcWrEn,
  output logic [31:0] pcWrData,
  output logic        statusRestore,
  output logic [31:0] baseOut
);
  seqStrobe_t st;
  logic abortCmd, lastBeat;

  mreg_xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .abortCmd(abortCmd),
    .lastBeat(lastBeat), .memReady(memReady), .cmdReady(cmdReady),
    .memReq(memReq), .done(done), .st(st)
  );

  mreg_xfer_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cmdList(cmdList),
    .cmdBaseIdx(cmdBaseIdx), .cmdBaseVal(cmdBaseVal), .cmdLoad(cmdLoad),
    .cmdMode(xferMode_t'(cmdMode)), .cmdWback(cmdWback),
    .cmdCondPass(cmdCondPass), .cmdCompact(cmdCompact),
    .cmdPopForm(cmdPopForm), .cmdExcRet(cmdExcRet), .abortCmd(abortCmd),
    .unpredictable(unpredictable), .lastBeat(lastBeat), .memAddr(memAddr),
    .memWrite(memWrite), .memWdata(memWdata), .memRdata(memRdata),
    .rfRdIdx(rfRdIdx), .rfRdData(rfRdData), .rfWrEn(rfWrEn),
    .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .pcWrEn(pcWrEn),
    .pcWrData(pcWrData), .statusRestore(statusRestore), .baseOut(baseOut)
  );

  // R11: address held while waiting for the memory
  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> $stable(memAddr));
  // R2: consecutive beats are one word apart
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady) |=> (!memReq || memAddr == $past(memAddr) + 32'd4));
  // R12: a rejected command starts no transfer
  assert_unpred_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    unpredictable |=> !memReq);
endmodule

// File: tb/sim_mreg_xfer.sv
module sim_mreg_xfer;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdReady;
  logic [15:0] cmdList = '0;
  logic [3:0]  cmdBaseIdx = '0;
  logic [31:0] cmdBaseVal = '0;
  logic        cmdLoad = 1'b0, cmdWback = 1'b0, cmdCondPass = 1'b1;
  logic [1:0]  cmdMode = 2'b10;
  logic        cmdCompact = 1'b0, cmdPopForm = 1'b0, cmdExcRet = 1'b0;
  logic        unpredictable, done, memReq, memWrite, memReady = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata, rfRdData, rfWrData, pcWrData, baseOut;
  logic [3:0]  rfRdIdx, rfWrIdx;
  logic        rfWrEn, pcWrEn, statusRestore;

  logic [31:0] rfModel [16];
  logic        pcSeen = 1'b0, statSeen = 1'b0;
  logic [31:0] pcVal = '0;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  mreg_xfer u0 (.*);

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction
  function automatic logic [31:0] rfInit(input int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h0101;
  endfunction
  function automatic int popc(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(v[i]);
    return n;
  endfunction

  assign rfRdData = rfModel[rfRdIdx];
  assign memRdata = memWord(memAddr);

  always @(posedge clk) begin
    if (rfWrEn) rfModel[rfWrIdx] <= rfWrData;
    if (pcWrEn) begin pcSeen <= 1'b1; pcVal <= pcWrData; end
    if (statusRestore) statSeen <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runCmd(input logic [15:0] list, input int bIdx, input logic [31:0] bVal,
                        input logic ld, input logic [1:0] md, input logic wb, input logic cp,
                        input logic cmpct, input logic pop, input logic exc);
    int cnt, nBeats, k, lowest;
    logic [31:0] size, start, last, expBase, expPc;
    logic [31:0] expRf [16];
    int expReg [17];
    logic unp, active, inc, bef, expPcSeen;
    cnt = popc(list);
    size = 32'(4 * cnt + (exc ? 4 : 0));
    inc = md[1]; bef = md[0];
    start = (inc ? bVal : bVal - size) + ((inc == bef) ? 32'd4 : 32'd0);
    last = start + size - 32'd4;
    unp = cp && (bIdx == 15 || (cmpct ? (cnt < 2 || (list[15] && list[14])) : cnt == 0)
          || (exc && (!ld || list[15])) || (pop && ld && list[15] && last[1:0] != 2'b00));
    active = cp && !unp;
    lowest = 0;
    for (int i = 15; i >= 0; i--) if (list[i]) lowest = i;
    nBeats = 0;
    if (active) begin
      for (int i = 0; i < 16; i++) if (list[i]) begin expReg[nBeats] = i; nBeats++; end
      if (exc) begin expReg[nBeats] = 15; nBeats++; end
    end
    for (int i = 0; i < 16; i++) begin
      rfModel[i] = rfInit(i);
      expRf[i] = rfInit(i);
    end
    if (bIdx < 15) begin rfModel[bIdx] = bVal; expRf[bIdx] = bVal; end
    expPcSeen = 1'b0; expPc = '0;
    for (int j = 0; j < nBeats; j++) begin
      if (ld && expReg[j] == 15) begin expPcSeen = 1'b1; expPc = memWord(start + 32'(4 * j)); end
      else if (ld) expRf[expReg[j]] = memWord(start + 32'(4 * j));
    end
    expBase = bVal;
    if (active && wb) begin
      expBase = (ld && list[bIdx[3:0]]) ? 32'd0 : (inc ? bVal + size : bVal - size);
      expRf[bIdx] = expBase;
    end
    pcSeen = 1'b0; statSeen = 1'b0;

    @(negedge clk);
    cmdList = list; cmdBaseIdx = 4'(bIdx); cmdBaseVal = bVal; cmdLoad = ld; cmdMode = md;
    cmdWback = wb; cmdCondPass = cp; cmdCompact = cmpct; cmdPopForm = pop; cmdExcRet = exc;
    cmdValid = 1'b1;
    #1;
    chk(cmdReady == 1'b1, "R11 ready when idle", 32'(cmdReady), 32'd1);
    chk(unpredictable == unp, "R12/R9/R7 unpredictable flag", 32'(unpredictable), 32'(unp));
    @(posedge clk);
    k = 0;
    for (int cyc = 0; cyc <= 200; cyc++) begin
      @(negedge clk);
      cmdValid = 1'b0;
      memReady = ($urandom % 4) != 0;
      #1;
      if (done) break;
      if (cyc == 200) chk(1'b0, "R11 watchdog on command", 32'(cyc), 32'd0);
      if (memReq) begin
        if (k >= nBeats) chk(1'b0, "R10/R2 unexpected access", memAddr, 32'd0);
        else if (memReady) begin
          chk(memAddr == start + 32'(4 * k), "R1/R2 address", memAddr, start + 32'(4 * k));
          chk(memWrite == !ld, "R2 direction", 32'(memWrite), 32'(!ld));
          if (!ld) begin
            logic [31:0] ew;
            ew = (wb && expReg[k] == bIdx && expReg[k] != lowest) ? 32'd0 : rfModel[expReg[k]];
            chk(memWdata == ew, "R5/R3 store data", memWdata, ew);
          end
          k++;
        end
      end
    end
    chk(k == nBeats, "R2 beat count", 32'(k), 32'(nBeats));
    chk(baseOut == expBase, "R4/R6 baseOut", baseOut, expBase);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R11 done single cycle", 32'(done), 32'd0);
    chk(pcSeen == expPcSeen, "R3/R8 branch strobe", 32'(pcSeen), 32'(expPcSeen));
    if (expPcSeen) chk(pcVal == expPc, "R3/R8 branch target", pcVal, expPc);
    chk(statSeen == (active && exc), "R8 status restore", 32'(statSeen), 32'(active && exc));
    for (int i = 0; i < 16; i++)
      chk(rfModel[i] == expRf[i], "R4/R6/R3 register file", rfModel[i], expRf[i]);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) rfModel[i] = rfInit(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(cmdReady && !memReq && !done, "R11 reset state", {29'd0, cmdReady, memReq, done}, 32'd4);
    // R1 R2: all four modes, stores and loads
    runCmd(16'h00F0, 2, 32'h0000_1000, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    runCmd(16'h8012, 3, 32'h0000_2000, 1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R3 R4
    runCmd(16'h0C03, 6, 32'h0000_3000, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    runCmd(16'h80A1, 9, 32'h0000_4000, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    runCmd(16'h8004, 13, 32'h0000_5000, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R3 store pc
    // R5: base listed, not lowest / lowest
    runCmd(16'h0061, 5, 32'h0000_6000, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    runCmd(16'h0060, 5, 32'h0000_6000, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R6: load with base in list
    runCmd(16'h0118, 4, 32'h0000_7000, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    runCmd(16'h0118, 4, 32'h0000_7000, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R7: pop of pc, unaligned then aligned
    runCmd(16'h8003, 13, 32'h0000_1002, 1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    runCmd(16'h8003, 13, 32'h0000_1000, 1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    // R8: exception return
    runCmd(16'h000F, 4, 32'h0000_8000, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    runCmd(16'h0006, 8, 32'h0000_8800, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    runCmd(16'h0006, 8, 32'h0000_8800, 1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    // R9: encoding rules
    runCmd(16'h0003, 15, 32'h0000_9000, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    runCmd(16'h0000, 2, 32'h0000_9000, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    runCmd(16'h0010, 2, 32'h0000_9000, 1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    runCmd(16'hC001, 2, 32'h0000_9000, 1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    runCmd(16'h0010, 2, 32'h0000_9000, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R10: condition fails
    runCmd(16'h00FF, 1, 32'h0000_A000, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // random full-encoding commands
    for (int n = 0; n < 300; n++) begin
      logic [15:0] l;
      l = 16'($urandom);
      if (l == '0) l = 16'h0001;
      runCmd(l, int'($urandom % 15), 32'h0001_0000 + 32'(($urandom % 1024) * 4),
             1'($urandom), 2'($urandom), 1'($urandom), ($urandom % 10) != 0,
             1'b0, 1'b0, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule